// File: doc/BRIEF.md
# Dual-Processor Mailbox with Interrupts

This block is a small shared register file through which a host processor and a coprocessor exchange short messages. It holds four mailboxes of two 16-bit words each. The host owns mailboxes 0 and 1, and the coprocessor owns mailboxes 2 and 3. Either side may read every word, but only the owner may write a mailbox.

A write by the owner to either word of a mailbox raises a level interrupt toward the other processor. The interrupt stays high until the receiving processor reads that mailbox. The owner reading back its own mailbox leaves the interrupt alone. If a set and a clear reach the same mailbox in the same cycle, the set wins, so a fresh message is never lost.

Each processor has its own synchronous port with an address, a write enable, a read enable, write data and read data. Each port also has an access-error pulse that flags a write to a mailbox the port does not own.

Top module: `dual_mbox`

## Requirements
- R1: The address on each port is 3 bits. Bits [2:1] select the mailbox (0 to 3) and bit 0 selects the word within it. Both ports can read all eight words.
- R2: A host write to addresses 0 to 3, or a coprocessor write to addresses 4 to 7, stores the write data in the addressed word. The new value is returned by any later read of that word from either port.
- R3: A write from a port to a mailbox it does not own changes no data word and no interrupt. In the cycle after that write, the port's error output is high for exactly one cycle. A write to an owned mailbox leaves the error output low.
- R4: An owner write to either word of mailbox m sets an interrupt, and the interrupt is visible after the clock edge that takes the write. For m = 0 or 1 the interrupt is irq_to_cop[m]; for m = 2 or 3 it is irq_to_host[m-2].
- R5: A read by the receiving port of either word of a mailbox clears that mailbox's interrupt, effective after the same edge that returns the read data. The receiving port is the coprocessor for mailboxes 0 and 1 and the host for mailboxes 2 and 3.
- R6: A read by the owning port of its own mailbox leaves the interrupt unchanged.
- R7: When an owner write and a receiver read hit the same mailbox in one cycle, the interrupt is set after the edge.
- R8: Read data appears on the port's rdata output one clock after the read enable and holds until that port's next read. A read and a write to the same word in one cycle return the word's previous contents.
- R9: While the synchronous active-high reset is high, every data word, every read data output, every error output and every interrupt goes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | 3 | Host word address |
| h_we | input | 1 | Host write enable |
| h_re | input | 1 | Host read enable |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, registered |
| h_err | output | 1 | Host pulse for a write to a mailbox the host does not own |
| c_addr | input | 3 | Coprocessor word address |
| c_we | input | 1 | Coprocessor write enable |
| c_re | input | 1 | Coprocessor read enable |
| c_wdata | input | 16 | Coprocessor write data |
| c_rdata | output | 16 | Coprocessor read data, registered |
| c_err | output | 1 | Coprocessor pulse for a write to a mailbox the coprocessor does not own |
| irq_to_cop | output | 2 | Interrupts for mailboxes 0 and 1, toward the coprocessor |
| irq_to_host | output | 2 | Interrupts for mailboxes 2 and 3, toward the host |

## Verification
The bench builds the block with its default 16-bit data width, which is the width the mailbox words are defined to have. Directed cases cover each ownership rule, the case where a set and a clear collide, and the case where a read and a write hit the same word.

A long run of random cycles then drives both ports with independent writes and reads over all eight addresses. This reaches every pairing of owner and foreign access, including both ports reading and writing in the same cycle.

// File: rtl/dual_mbox.sv
module dual_mbox #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    h_addr,
  input  logic          h_we,
  input  logic          h_re,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          h_err,
  input  logic [2:0]    c_addr,
  input  logic          c_we,
  input  logic          c_re,
  input  logic [DW-1:0] c_wdata,
  output logic [DW-1:0] c_rdata,
  output logic          c_err,
  output logic [1:0]    irq_to_cop,
  output logic [1:0]    irq_to_host
);
  localparam int NMB  = 4;
  localparam int NREG = 2 * NMB;
  localparam int HALF = NMB / 2;

  logic [NREG-1:0][DW-1:0] regs;
  logic [NMB-1:0]          flag;

  wire [1:0] h_mb  = h_addr[2:1];
  wire [1:0] c_mb  = c_addr[2:1];
  wire       h_wok = h_we & ~h_mb[1];
  wire       c_wok = c_we &  c_mb[1];

  assign irq_to_cop  = flag[HALF-1:0];
  assign irq_to_host = flag[NMB-1:HALF];

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else begin
      if (h_wok) regs[h_addr] <= h_wdata;
      if (c_wok) regs[c_addr] <= c_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= '0;
    end else begin
      for (int m = 0; m < NMB; m++) begin
        if (m < HALF) begin
          if (h_wok && h_mb == m)      flag[m] <= 1'b1;
          else if (c_re && c_mb == m)  flag[m] <= 1'b0;
        end else begin
          if (c_wok && c_mb == m)      flag[m] <= 1'b1;
          else if (h_re && h_mb == m)  flag[m] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rdata <= '0;
      c_rdata <= '0;
      h_err   <= 1'b0;
      c_err   <= 1'b0;
    end else begin
      if (h_re) h_rdata <= regs[h_addr];
      if (c_re) c_rdata <= regs[c_addr];
      h_err <= h_we & ~h_wok;
      c_err <= c_we & ~c_wok;
    end
  end

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (flag == '0 && h_rdata == '0 && c_rdata == '0 && !h_err && !c_err));

  a_r4_host_write_sets: assert property (@(posedge clk) disable iff (rst)
    (h_we && h_addr[2:1] == 2'd0) |=> irq_to_cop[0]);

  a_r4_cop_write_sets: assert property (@(posedge clk) disable iff (rst)
    (c_we && c_addr[2:1] == 2'd3) |=> irq_to_host[1]);

  a_r5_cop_read_clears: assert property (@(posedge clk) disable iff (rst)
    (c_re && c_addr[2:1] == 2'd1 && !(h_we && h_addr[2:1] == 2'd1)) |=> !irq_to_cop[1]);

  a_r6_owner_read_keeps: assert property (@(posedge clk) disable iff (rst)
    (irq_to_host[0] && !(h_re && h_addr[2:1] == 2'd2)) |=> irq_to_host[0]);

  a_r3_foreign_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (h_we && h_addr[2] && !c_we) |=> (regs == $past(regs) && h_err));

  a_r3_err_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (h_err && !$past(h_we)) |-> 1'b0);

  a_r8_read_holds: assert property (@(posedge clk) disable iff (rst)
    !h_re |=> $stable(h_rdata));
endmodule

// File: tb/tb_dual_mbox.sv
`timescale 1ns/1ps
module tb_dual_mbox;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] h_addr = '0, c_addr = '0;
  logic h_we = 0, h_re = 0, c_we = 0, c_re = 0;
  logic [15:0] h_wdata = '0, c_wdata = '0;
  logic [15:0] h_rdata, c_rdata;
  logic h_err, c_err;
  logic [1:0] irq_to_cop, irq_to_host;

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [15:0] m_mem [8];
  logic [3:0]  m_flag;
  logic [15:0] m_hr, m_cr;
  logic        m_he, m_ce;

  always #2.5 clk = ~clk;

  dual_mbox dut (.*);

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "h_rdata", h_rdata, m_hr);
    chk(tag, "c_rdata", c_rdata, m_cr);
    chk(tag, "h_err", {15'd0, h_err}, {15'd0, m_he});
    chk(tag, "c_err", {15'd0, c_err}, {15'd0, m_ce});
    chk(tag, "irq_to_cop", {14'd0, irq_to_cop}, {14'd0, m_flag[1:0]});
    chk(tag, "irq_to_host", {14'd0, irq_to_host}, {14'd0, m_flag[3:2]});
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_mem[i] = '0;
    m_flag = '0; m_hr = '0; m_cr = '0; m_he = 0; m_ce = 0;
  endtask

  task automatic model_step();
    logic [15:0] nm [8];
    for (int i = 0; i < 8; i++) nm[i] = m_mem[i];
    if (h_re) m_hr = m_mem[h_addr];
    if (c_re) m_cr = m_mem[c_addr];
    m_he = h_we && h_addr[2];
    m_ce = c_we && !c_addr[2];
    for (int m = 0; m < 4; m++) begin
      if (m < 2) begin
        if (h_we && !h_addr[2] && h_addr[2:1] == m) m_flag[m] = 1'b1;
        else if (c_re && c_addr[2:1] == m) m_flag[m] = 1'b0;
      end else begin
        if (c_we && c_addr[2] && c_addr[2:1] == m) m_flag[m] = 1'b1;
        else if (h_re && h_addr[2:1] == m) m_flag[m] = 1'b0;
      end
    end
    if (h_we && !h_addr[2]) nm[h_addr] = h_wdata;
    if (c_we && c_addr[2])  nm[c_addr] = c_wdata;
    for (int i = 0; i < 8; i++) m_mem[i] = nm[i];
  endtask

  task automatic cyc(string tag, bit hwe, bit hre, logic [2:0] ha, logic [15:0] hd,
                     bit cwe, bit cre, logic [2:0] ca, logic [15:0] cd);
    @(negedge clk);
    h_we = hwe; h_re = hre; h_addr = ha; h_wdata = hd;
    c_we = cwe; c_re = cre; c_addr = ca; c_wdata = cd;
    @(posedge clk);
    model_step();
    #1;
    check_all(tag);
  endtask

  initial begin
    #500000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check_all("R9");
    @(negedge clk); rst = 0;

    // R2/R4: host writes word 1 of mailbox 0, coprocessor reads it back (R1 mapping)
    cyc("R4", 1,0,3'd1,16'hA5A5, 0,0,3'd0,16'h0);
    cyc("R5", 0,0,3'd0,16'h0,    0,1,3'd1,16'h0);
    cyc("R2", 0,1,3'd1,16'h0,    0,0,3'd0,16'h0);
    // R6: owner read keeps flag
    cyc("R4", 0,0,3'd0,16'h0,    1,0,3'd4,16'h1234);
    cyc("R6", 0,0,3'd0,16'h0,    0,1,3'd5,16'h0);
    cyc("R5", 0,1,3'd5,16'h0,    0,0,3'd0,16'h0);
    cyc("R1", 0,1,3'd4,16'h0,    0,1,3'd4,16'h0);
    // R3: foreign writes from each side
    cyc("R3", 1,0,3'd6,16'hDEAD, 1,0,3'd2,16'hBEEF);
    cyc("R3", 0,1,3'd6,16'h0,    0,1,3'd2,16'h0);
    // R7: set wins over clear, both directions
    cyc("R7", 1,0,3'd2,16'h0102, 0,1,3'd3,16'h0);
    cyc("R7", 0,1,3'd7,16'h0,    1,0,3'd7,16'h0304);
    // R8: same-cycle read and write of one word returns old value
    cyc("R8", 1,1,3'd2,16'h7777, 0,0,3'd0,16'h0);
    cyc("R8", 0,0,3'd0,16'h0,    0,0,3'd0,16'h0);
    cyc("R8", 0,1,3'd2,16'h0,    0,1,3'd2,16'h0);

    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 4000; i++) begin
      cyc("R2", ($urandom % 3) == 0, ($urandom % 2) == 0, 3'($urandom), 16'($urandom),
                ($urandom % 3) == 0, ($urandom % 2) == 0, 3'($urandom), 16'($urandom));
    end

    @(negedge clk); rst = 1; h_we = 0; c_we = 0; h_re = 0; c_re = 0;
    @(posedge clk); model_reset(); #1;
    check_all("R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule